// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the fixed, automatic part of taking an interrupt and of leaving one. When the interrupt controller pulses `accept`, the sequencer captures the live program counter and status byte. It writes them to a byte-wide stack that sits in memory page 1, fetches the handler address from a per-source vector slot, and hands the new program counter and a status byte with the interrupt-disable bit set back to the core. When the instruction decoder pulses `rti`, the sequencer reads the three saved bytes back in the opposite order and restores status and program counter.

The block owns the 8-bit stack pointer. The core may load it through `sp_set` while the sequencer is idle. The memory bus is byte wide with combinational read data: a byte is taken from `mem_rdata` in the same cycle its address is driven. Both sequences run for a fixed number of cycles, and each ends with a one-cycle `done` strobe that coincides with the program-counter update.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_we`, `pc_we` and `ps_we` are 0 and `sp` equals `SP_INIT`.
- R2: An entry writes three bytes, in this order, on the 2nd, 3rd and 4th cycles after the edge that samples `accept`: PC high byte at 0x0100+SP, PC low byte at 0x0100+SP-1, then status at 0x0100+SP-2. Each push post-decrements SP by one, modulo 256.
- R3: The status byte pushed is the `ps_in` value captured at acceptance. In the cycle of that push `ps_we` is high and `ps_out` equals that value with bit `IDIS_BIT` (default 2) forced to 1.
- R4: An entry reads the vector low byte at `VEC_TOP - 2*irq_src` and the high byte at the next address. It then drives `pc_out` = {high, low} with `pc_we` high.
- R5: An entry keeps `busy` high for exactly 7 cycles, and `done` pulses for one cycle in the 7th.
- R6: A return reads status at 0x0100+SP+1 (driving `ps_out` with `ps_we`), PC low at SP+2 and PC high at SP+3, pre-incrementing SP for each. It then drives the restored PC with `pc_we`.
- R7: A return keeps `busy` high for exactly 6 cycles, and `done` pulses in the 6th.
- R8: `accept` and `rti` are ignored while `busy` is high. When both are high in an idle cycle, the entry sequence is taken.
- R9: `sp_set` loads `sp_val` into SP only when idle. While busy it has no effect.
- R10: `mem_we` is high only during the three push cycles of an entry. A return never writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept | input | 1 | Interrupt accepted pulse |
| irq_src | input | SRC_W | Index of the accepted source |
| rti | input | 1 | Return-from-interrupt command pulse |
| sp_set | input | 1 | Load stack pointer |
| sp_val | input | 8 | Stack pointer load value |
| pc_in | input | 16 | Live program counter |
| ps_in | input | 8 | Live status byte |
| mem_rdata | input | 8 | Memory read data (same cycle as address) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp | output | 8 | Stack pointer |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Program counter update strobe |
| ps_out | output | 8 | New status byte |
| ps_we | output | 1 | Status update strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |

## Verification
The bench builds the sequencer with `SRC_W` = 3, `VEC_TOP` = 0xFFF0 and `SP_INIT` = 0xFF. Eight sources therefore land on distinct vector slots that are well inside the top page. The default stack pointer lets a nested pair of entries run without reloading. Loading SP near zero then takes pushes across the page-1 wrap from 0x0100 to 0x01FF and takes the matching pops back over it.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          SRC_W    = 4,
  parameter logic [15:0] VEC_TOP  = 16'hFFFE,
  parameter logic [7:0]  SP_INIT  = 8'hFF,
  parameter int          IDIS_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SRC_W-1:0] irq_src,
  input  logic             rti,
  input  logic             sp_set,
  input  logic [7:0]       sp_val,
  input  logic [15:0]      pc_in,
  input  logic [7:0]       ps_in,
  input  logic [7:0]       mem_rdata,
  output logic [15:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  output logic [7:0]       sp,
  output logic [15:0]      pc_out,
  output logic             pc_we,
  output logic [7:0]       ps_out,
  output logic             ps_we,
  output logic             busy,
  output logic             done
);
  localparam logic [7:0] STK_PAGE = 8'h01;
  localparam logic [7:0] DIS_MASK = 8'(1) << IDIS_BIT;
  localparam logic [2:0] ENT_LAST = 3'd6;
  localparam logic [2:0] RET_LAST = 3'd5;

  typedef enum logic [1:0] {M_IDLE, M_ENT, M_RET} mode_t;

  mode_t       mode;
  logic [2:0]  step;
  logic [15:0] pc_sv;
  logic [7:0]  ps_sv;
  logic [15:0] vaddr;
  logic [7:0]  lo_b, hi_b;

  wire in_ent = (mode == M_ENT);
  wire in_ret = (mode == M_RET);
  wire push   = in_ent && (step >= 3'd1) && (step <= 3'd3);
  wire pop    = in_ret && (step >= 3'd1) && (step <= 3'd3);
  wire [15:0] vec_off = {{(15-SRC_W){1'b0}}, irq_src, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= M_IDLE;
      step  <= 3'd0;
      sp    <= SP_INIT;
      pc_sv <= 16'd0;
      ps_sv <= 8'd0;
      vaddr <= 16'd0;
      lo_b  <= 8'd0;
      hi_b  <= 8'd0;
    end else begin
      case (mode)
        M_IDLE: begin
          step <= 3'd0;
          if (accept) begin
            mode  <= M_ENT;
            pc_sv <= pc_in;
            ps_sv <= ps_in;
            vaddr <= VEC_TOP - vec_off;
          end else if (rti) begin
            mode <= M_RET;
          end else if (sp_set) begin
            sp <= sp_val;
          end
        end
        M_ENT: begin
          step <= step + 3'd1;
          if (push) sp <= sp - 8'd1;
          if (step == 3'd4) lo_b <= mem_rdata;
          if (step == 3'd5) hi_b <= mem_rdata;
          if (step == ENT_LAST) mode <= M_IDLE;
        end
        M_RET: begin
          step <= step + 3'd1;
          if (pop) sp <= sp + 8'd1;
          if (step == 3'd2) lo_b <= mem_rdata;
          if (step == 3'd3) hi_b <= mem_rdata;
          if (step == RET_LAST) mode <= M_IDLE;
        end
        default: mode <= M_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr = 16'd0;
    if (push)                        mem_addr = {STK_PAGE, sp};
    else if (pop)                    mem_addr = {STK_PAGE, sp + 8'd1};
    else if (in_ent && step == 3'd4) mem_addr = vaddr;
    else if (in_ent && step == 3'd5) mem_addr = vaddr + 16'd1;
  end

  always_comb begin
    mem_wdata = 8'd0;
    if (in_ent) begin
      case (step)
        3'd1:    mem_wdata = pc_sv[15:8];
        3'd2:    mem_wdata = pc_sv[7:0];
        3'd3:    mem_wdata = ps_sv;
        default: mem_wdata = 8'd0;
      endcase
    end
  end

  assign mem_we = push;
  assign busy   = (mode != M_IDLE);
  assign done   = (in_ent && step == ENT_LAST) || (in_ret && step == RET_LAST);
  assign pc_we  = done;
  assign pc_out = {hi_b, lo_b};
  assign ps_we  = (in_ent && step == 3'd3) || (in_ret && step == 3'd1);
  assign ps_out = in_ent ? (ps_sv | DIS_MASK) : mem_rdata;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int IDIS_BIT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp,
  input logic        ps_we,
  input logic [7:0]  ps_out
);
  assert_push_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == 8'h01);

  assert_push_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - 8'd1);

  assert_disable_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_we && mem_we) |-> ps_out[IDIS_BIT]);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_no_idle_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.IDIS_BIT(IDIS_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_we(mem_we),
  .mem_addr(mem_addr), .sp(sp), .ps_we(ps_we), .ps_out(ps_out)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int          SRC_W   = 3;
  localparam logic [15:0] VEC_TOP = 16'hFFF0;
  localparam logic [7:0]  DMASK   = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accept = 1'b0, rti = 1'b0, sp_set = 1'b0;
  logic [SRC_W-1:0] irq_src = '0;
  logic [7:0]  sp_val = 8'd0, ps_in = 8'd0, mem_rdata, mem_wdata, sp, ps_out;
  logic [15:0] pc_in = 16'd0, mem_addr, pc_out;
  logic mem_we, pc_we, ps_we, busy, done;

  always #4 clk = ~clk;

  irq_entry_seq #(.SRC_W(SRC_W), .VEC_TOP(VEC_TOP), .SP_INIT(8'hFF)) i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .irq_src(irq_src), .rti(rti),
    .sp_set(sp_set), .sp_val(sp_val), .pc_in(pc_in), .ps_in(ps_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .sp(sp), .pc_out(pc_out), .pc_we(pc_we),
    .ps_out(ps_out), .ps_we(ps_we), .busy(busy), .done(done));

  logic [7:0] stk [256];
  function automatic logic [7:0] vbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction
  always_comb mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vbyte(mem_addr);
  always_ff @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  typedef struct { int k; logic [15:0] a; logic [15:0] d; string r; } ev_t;
  ev_t q[$];
  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0]  msp = 8'hFF;
  logic [23:0] frames[$];

  task automatic check(input bit ok, input string r, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input logic [15:0] a, input logic [15:0] d, input string r);
    ev_t e; e.k = k; e.a = a; e.d = d; e.r = r; q.push_back(e);
  endtask

  task automatic take(input int k, input logic [15:0] a, input logic [15:0] d);
    ev_t e;
    if (q.size() == 0) begin
      check(0, "R10", $sformatf("unexpected event kind %0d", k), d, 16'h0);
      return;
    end
    e = q.pop_front();
    check(e.k == k && e.a == a && e.d == d, e.r,
          $sformatf("event kind %0d/%0d addr %h/%h", k, e.k, a, e.a), d, e.d);
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (mem_we) take(0, mem_addr, {8'h00, mem_wdata});
    if (ps_we)  take(1, 16'h0, {8'h00, ps_out});
    if (pc_we)  take(2, 16'h0, pc_out);
  end

  task automatic wait_done(output int n);
    n = 1;
    while (!done) begin @(negedge clk); n++; end
  endtask

  // poke: 0 none, 1 accept while busy, 2 sp_set while busy, 3 rti while busy
  task automatic do_entry(input logic [15:0] pc, input logic [7:0] ps,
                          input logic [SRC_W-1:0] src, input int poke, input bit with_rti);
    logic [15:0] v;
    int n;
    v = VEC_TOP - 16'(2 * int'(src));
    expect_ev(0, {8'h01, msp},          {8'h00, pc[15:8]}, "R2");
    expect_ev(0, {8'h01, msp - 8'd1},   {8'h00, pc[7:0]},  "R2");
    expect_ev(0, {8'h01, msp - 8'd2},   {8'h00, ps},       "R3");
    expect_ev(1, 16'h0, {8'h00, ps | DMASK}, "R3");
    expect_ev(2, 16'h0, {vbyte(v + 16'd1), vbyte(v)}, "R4");
    msp = msp - 8'd3;
    frames.push_back({pc, ps});
    @(negedge clk);
    accept = 1'b1; rti = with_rti; pc_in = pc; ps_in = ps; irq_src = src;
    @(negedge clk);
    accept = 1'b0; rti = 1'b0; pc_in = 16'hDEAD; ps_in = 8'hEE; irq_src = '0;
    n = 1;
    while (!done) begin
      if (n == 3 && poke == 1) accept = 1'b1;
      if (n == 3 && poke == 2) begin sp_set = 1'b1; sp_val = 8'h55; end
      if (n == 3 && poke == 3) rti = 1'b1;
      @(negedge clk); n++;
      accept = 1'b0; sp_set = 1'b0; rti = 1'b0;
    end
    check(n == 7, "R5", "entry length", 16'(n), 16'd7);
    check(sp == msp, poke == 2 ? "R9" : "R2", "sp after entry", {8'h0, sp}, {8'h0, msp});
    @(negedge clk);
    check(!busy && !done, "R8", "idle after entry", {15'h0, busy}, 16'h0);
  endtask

  task automatic do_return(input int poke);
    logic [23:0] f;
    int n;
    f = frames.pop_back();
    expect_ev(1, 16'h0, {8'h00, f[7:0]}, "R6");
    expect_ev(2, 16'h0, f[23:8], "R6");
    msp = msp + 8'd3;
    @(negedge clk);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    n = 1;
    while (!done) begin
      if (n == 2 && poke == 1) accept = 1'b1;
      @(negedge clk); n++;
      accept = 1'b0;
    end
    check(n == 6, "R7", "return length", 16'(n), 16'd6);
    check(sp == msp, "R6", "sp after return", {8'h0, sp}, {8'h0, msp});
    @(negedge clk);
    check(!busy, "R8", "idle after return", {15'h0, busy}, 16'h0);
  endtask

  task automatic load_sp(input logic [7:0] v);
    @(negedge clk); sp_set = 1'b1; sp_val = v;
    @(negedge clk); sp_set = 1'b0;
    msp = v;
    check(sp == v, "R9", "sp load when idle", {8'h0, sp}, {8'h0, v});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_we && !pc_we && !ps_we, "R1", "outputs in reset",
          {11'h0, busy, done, mem_we, pc_we, ps_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sp == 8'hFF, "R1", "sp after reset", {8'h0, sp}, 16'h00FF);
    check(!busy, "R1", "idle after reset", {15'h0, busy}, 16'h0);

    do_entry(16'h1234, 8'h81, 3'd0, 0, 0);
    do_return(0);
    do_entry(16'hA55A, 8'h00, 3'd5, 0, 0);
    do_entry(16'h0F0F, 8'h3B, 3'd7, 1, 0);
    do_return(1);
    do_return(0);
    load_sp(8'h01);
    do_entry(16'hC0DE, 8'hF0, 3'd2, 2, 0);
    check(sp == 8'hFE, "R2", "sp wrapped", {8'h0, sp}, 16'h00FE);
    do_return(0);
    check(sp == 8'h01, "R6", "sp unwrapped", {8'h0, sp}, 16'h0001);
    do_entry(16'h7E57, 8'h04, 3'd3, 3, 1);
    do_return(0);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R10", "pending expected events", 16'(q.size()), 16'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule